// File: doc/BRIEF.md
# Byte Single-Error-Correcting Codec (12-bit Positional Hamming)

This block protects one data byte with four check bits in a 12-bit stored word. The encoder side has no clock. It turns a byte into a codeword in the same cycle, with the check bits placed at the power-of-two positions and the data bits in the positions between them. The decoder side takes a word read back from storage, one word per cycle when its valid input is high. It computes a 4-bit syndrome whose value is the 1-based position of a single flipped bit. It inverts that bit and, one cycle later, presents the repaired byte together with the syndrome and two flags.

The positional layout makes the syndrome an address, so no lookup table is needed. A syndrome that lands on a check-bit position repairs nothing in the byte, but the block still reports it as a corrected event. A syndrome that lands past the last position cannot come from a single error. In that case the block flags the word as uncorrectable and returns the raw data bits.

Top module: `hamm_codec`

## Requirements
- R1: Codeword bit index i holds position i+1. Positions 1, 2, 4 and 8 are check bits c1, c2, c3 and c4. Data bit k (d(k+1), k = 0..7) sits at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order.
- R2: The check bits obey c1 = d1^d2^d4^d5^d7, c2 = d1^d3^d4^d6^d7, c3 = d2^d3^d4^d8 and c4 = d5^d6^d7^d8. For example, byte 0xCD encodes to 12'hC6D.
- R3: The encoder output depends only on the current encoder input, with no clock, and every codeword it produces has a zero syndrome.
- R4: Syndrome bit j (weight 2^j, so bit 3 has weight 8 and bit 0 has weight 1) is the XOR of every received position whose number has bit j set. dec_syn_o reports this value. For a single flipped bit it equals that bit's position, so 12'hC4D gives syndrome 6.
- R5: A zero syndrome passes the data bits through unchanged, with both flags low.
- R6: A syndrome that names a data position inverts that bit, returns the original byte and raises dec_corr_o.
- R7: A syndrome of 1, 2, 4 or 8 leaves the returned byte equal to the received data bits and raises dec_corr_o.
- R8: A syndrome of 13, 14 or 15 raises dec_bad_o, keeps dec_corr_o low and returns the received data bits unmodified. dec_corr_o and dec_bad_o are never high together.
- R9: dec_valid_o is high exactly one cycle after dec_valid_i. When dec_valid_i is low, the data, syndrome and flag outputs keep their values.
- R10: A synchronous active-high rst clears dec_valid_o, dec_data_o, dec_syn_o, dec_corr_o and dec_bad_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_data_i | input | 8 | Byte to encode |
| enc_cw_o | output | 12 | Codeword for enc_data_i, combinational |
| dec_valid_i | input | 1 | A read word is present on dec_cw_i |
| dec_cw_i | input | 12 | Read word to decode |
| dec_valid_o | output | 1 | Decoded result is valid, one cycle after dec_valid_i |
| dec_data_o | output | 8 | Repaired (or raw, when uncorrectable) data byte |
| dec_syn_o | output | 4 | Syndrome of the read word |
| dec_corr_o | output | 1 | A single-bit error was corrected |
| dec_bad_o | output | 1 | Syndrome points beyond position 12 |

## Verification
Four properties are checked on every cycle: the valid pipeline delay, the holding of results while no word arrives, the mutual exclusion of the two flags together with the zero-syndrome and out-of-range conditions behind them, and a zero syndrome on the encoder's own output. Whether the repaired byte equals the byte originally stored can only be shown by the bench's scenarios. To show it, the bench injects every single flip into every byte value, replays the worked vector and its position-6 flip, and builds double flips that push the syndrome to 13, 14 and 15. Reset clearing, both at start-up and in the middle of a run, is also shown only by directed scenarios.

// File: rtl/hamm_pkg.sv
package hamm_pkg;
  localparam int DATA_W = 8;
  localparam int PAR_W  = 4;
  localparam int CW_W   = DATA_W + PAR_W;

  // 1-based codeword position of data bit k: the k-th position that is not a power of two
  function automatic int data_pos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // XOR of all positions whose index has bit j set
  function automatic logic [PAR_W-1:0] cw_syndrome(input logic [CW_W-1:0] cw);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      for (int j = 0; j < PAR_W; j++) begin
        if (((p >> j) & 1) == 1) s[j] = s[j] ^ cw[p-1];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/hamm_enc.sv
module hamm_enc
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] cw_o
);
  always_comb begin
    logic chk;
    cw_o = '0;
    for (int k = 0; k < DW; k++) begin
      cw_o[data_pos(k)-1] = data_i[k];
    end
    for (int j = 0; j < PW; j++) begin
      chk = 1'b0;
      for (int k = 0; k < DW; k++) begin
        if (((data_pos(k) >> j) & 1) == 1) chk = chk ^ data_i[k];
      end
      cw_o[(1 << j) - 1] = chk;
    end
  end
endmodule

// File: rtl/hamm_syndrome.sv
module hamm_syndrome
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic [CW-1:0] cw_i,
  output logic [PW-1:0] syn_o
);
  // one XOR tree per check bit, built by generate
  for (genvar j = 0; j < PW; j++) begin : g_chk
    logic [CW-1:0] mask;
    always_comb begin
      mask = '0;
      for (int p = 1; p <= CW; p++) begin
        if (((p >> j) & 1) == 1) mask[p-1] = 1'b1;
      end
    end
    assign syn_o[j] = ^(cw_i & mask);
  end
endmodule

// File: rtl/hamm_fix.sv
module hamm_fix
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic [CW-1:0] cw_i,
  input  logic [PW-1:0] syn_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          bad_o
);
  logic [CW-1:0] fixed;

  always_comb begin
    fixed  = cw_i;
    corr_o = 1'b0;
    bad_o  = 1'b0;
    if (syn_i != '0) begin
      if (int'(syn_i) <= CW) begin
        corr_o = 1'b1;
        fixed[int'(syn_i) - 1] = ~cw_i[int'(syn_i) - 1];
      end else begin
        bad_o = 1'b1;
      end
    end
    for (int k = 0; k < DW; k++) begin
      data_o[k] = fixed[data_pos(k)-1];
    end
  end
endmodule

// File: rtl/hamm_dec.sv
module hamm_dec
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [CW-1:0] cw_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [PW-1:0] syn_o,
  output logic          corr_o,
  output logic          bad_o
);
  logic [PW-1:0] syn_c;
  logic [DW-1:0] data_c;
  logic          corr_c;
  logic          bad_c;

  hamm_syndrome #(.DW(DW), .PW(PW)) u_syn (
    .cw_i  (cw_i),
    .syn_o (syn_c)
  );

  hamm_fix #(.DW(DW), .PW(PW)) u_fix (
    .cw_i   (cw_i),
    .syn_i  (syn_c),
    .data_o (data_c),
    .corr_o (corr_c),
    .bad_o  (bad_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      syn_o   <= '0;
      corr_o  <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= data_c;
        syn_o  <= syn_c;
        corr_o <= corr_c;
        bad_o  <= bad_c;
      end
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(data_o) && $stable(syn_o) && $stable(corr_o) && $stable(bad_o)));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(corr_o && bad_o));
  // R5
  clean_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && syn_o == '0) |-> (!corr_o && !bad_o));
  // R8
  bad_range_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && bad_o) |-> (int'(syn_o) > CW));
endmodule

// File: rtl/hamm_codec.sv
module hamm_codec
  import hamm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  localparam int CW = DW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_cw_o,
  input  logic          dec_valid_i,
  input  logic [CW-1:0] dec_cw_i,
  output logic          dec_valid_o,
  output logic [DW-1:0] dec_data_o,
  output logic [PW-1:0] dec_syn_o,
  output logic          dec_corr_o,
  output logic          dec_bad_o
);
  hamm_enc #(.DW(DW), .PW(PW)) u_enc (
    .data_i (enc_data_i),
    .cw_o   (enc_cw_o)
  );

  hamm_dec #(.DW(DW), .PW(PW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .valid_i (dec_valid_i),
    .cw_i    (dec_cw_i),
    .valid_o (dec_valid_o),
    .data_o  (dec_data_o),
    .syn_o   (dec_syn_o),
    .corr_o  (dec_corr_o),
    .bad_o   (dec_bad_o)
  );

  // R3
  enc_clean_chk: assert property (@(posedge clk) disable iff (rst)
    cw_syndrome(enc_cw_o) == '0);
endmodule

// File: tb/hamm_codec_tb.sv
module hamm_codec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  enc_data_i = '0;
  logic [11:0] enc_cw_o;
  logic        dec_valid_i = 1'b0;
  logic [11:0] dec_cw_i = '0;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic [3:0]  dec_syn_o;
  logic        dec_corr_o;
  logic        dec_bad_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hamm_codec u_dut (
    .clk(clk), .rst(rst), .enc_data_i(enc_data_i), .enc_cw_o(enc_cw_o),
    .dec_valid_i(dec_valid_i), .dec_cw_i(dec_cw_i), .dec_valid_o(dec_valid_o),
    .dec_data_o(dec_data_o), .dec_syn_o(dec_syn_o), .dec_corr_o(dec_corr_o),
    .dec_bad_o(dec_bad_o)
  );

  // encoder written from the check equations, positions per R1/R2
  function automatic logic [11:0] ref_enc(input logic [7:0] d);
    logic [11:0] c;
    c[0]  = d[0]^d[1]^d[3]^d[4]^d[6];
    c[1]  = d[0]^d[2]^d[3]^d[5]^d[6];
    c[2]  = d[0];
    c[3]  = d[1]^d[2]^d[3]^d[7];
    c[4]  = d[1];
    c[5]  = d[2];
    c[6]  = d[3];
    c[7]  = d[4]^d[5]^d[6]^d[7];
    c[8]  = d[4];
    c[9]  = d[5];
    c[10] = d[6];
    c[11] = d[7];
    return c;
  endfunction

  // {cw_in, data, syn, corr, bad}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {12'hC6D, 8'hCD, 4'd0,  1'b0, 1'b0},
    {12'hC4D, 8'hCD, 4'd6,  1'b1, 1'b0},
    {12'hC6C, 8'hCD, 4'd1,  1'b1, 1'b0},
    {12'hCED, 8'hCD, 4'd8,  1'b1, 1'b0},
    {12'h46C, 8'h4D, 4'd13, 1'b0, 1'b1},
    {12'h46F, 8'h4D, 4'd14, 1'b0, 1'b1},
    {12'h469, 8'h4C, 4'd15, 1'b0, 1'b1},
    {12'h000, 8'h00, 4'd0,  1'b0, 1'b0},
    {12'hFFF, 8'h7F, 4'd12, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_dec(input logic [11:0] cw);
    @(negedge clk);
    dec_cw_i = cw;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {17'd0, dec_valid_o, dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o};
  endfunction

  initial begin
    logic [14:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", outs(), 32'd0);

    // R2 worked vector on encoder, combinational R3
    enc_data_i = 8'hCD;
    #1;
    chk("R2 R3 encode 0xCD", {20'd0, enc_cw_o}, 32'hC6D);

    // table of vectors: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      run_dec(VEC[i][25:14]);
      chk("R9 valid after one cycle", {31'd0, dec_valid_o}, 32'd1);
      chk("R4 syndrome", {28'd0, dec_syn_o}, {28'd0, VEC[i][5:2]});
      chk("R5 R6 R7 R8 data", {24'd0, dec_data_o}, {24'd0, VEC[i][13:6]});
      chk("R6 R7 corr flag", {31'd0, dec_corr_o}, {31'd0, VEC[i][1]});
      chk("R8 bad flag", {31'd0, dec_bad_o}, {31'd0, VEC[i][0]});
    end

    // exhaustive: every byte, clean and every single flip
    for (int d = 0; d < 256; d++) begin
      logic [11:0] good;
      enc_data_i = d[7:0];
      #1;
      good = ref_enc(d[7:0]);
      chk("R1 R2 encoder", {20'd0, enc_cw_o}, {20'd0, good});
      for (int p = 0; p <= 12; p++) begin
        logic [11:0] flip;
        flip = (p == 0) ? 12'd0 : (12'd1 << (p - 1));
        run_dec(good ^ flip);
        if (p == 0)
          chk("R5 clean pass", {17'd0, dec_valid_o, dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o},
              {17'd0, 1'b1, d[7:0], 4'd0, 1'b0, 1'b0});
        else if (p == 1 || p == 2 || p == 4 || p == 8)
          chk("R7 check-bit flip", {17'd0, dec_valid_o, dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o},
              {17'd0, 1'b1, d[7:0], 4'(p), 1'b1, 1'b0});
        else
          chk("R4 R6 data-bit flip", {17'd0, dec_valid_o, dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o},
              {17'd0, 1'b1, d[7:0], 4'(p), 1'b1, 1'b0});
      end
    end

    // R9 hold when no valid word
    run_dec(12'hC4D);
    held = {dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o};
    @(negedge clk);
    dec_cw_i = 12'h46C;
    @(negedge clk);
    chk("R9 valid low when idle", {31'd0, dec_valid_o}, 32'd0);
    chk("R9 outputs held", {17'd0, dec_data_o, dec_syn_o, dec_corr_o, dec_bad_o}, {17'd0, held});

    // R10 reset in mid run
    run_dec(12'hFFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-run reset", outs(), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule